// File: doc/BRIEF.md
# I2C slave address-match status logic

This block sits behind the bit-level receiver of an I2C slave. When the receiver presents a complete 7-bit address, the block works out which kind of call it is. The candidates are either of the two own addresses, the general call address, the SMBus host address and the SMBus device default address. The result is held as flags in a 16-bit status word. Any accepted match also raises an address-matched flag, which software acknowledges by reading the first status word and then the second.

The match flags live for one address phase. A STOP clears them, as does a START seen while the bus is already busy (a repeated START), and so does dropping the peripheral enable. The block tracks bus busy itself from the START and STOP pulses. A START on an idle bus therefore leaves the flags alone. The upper byte of the status word shows the running PEC value supplied from outside, but only while PEC is enabled.

Top module: `i2c_addr_status`

## Requirements
- R1: After reset `status_o` is 0x0000 and `addr_o` is 0.
- R2: An address byte accepted with `addr_valid_i` sets `addr_o` one cycle later when it equals either own address. The dual flag (bit 7) reads 0 for an own-address-1 match and 1 for an own-address-2 match. An address that matches nothing leaves `addr_o` and the flags unchanged.
- R3: Address 7'h00 sets the general-call flag (bit 4) and `addr_o` only while `gc_en_i` is high.
- R4: Address 7'h08 sets the SMBus-host flag (bit 6) and `addr_o` only while both `arp_en_i` and `host_type_i` are high.
- R5: Address 7'h61 sets the SMBus-default flag (bit 5) and `addr_o` only while `arp_en_i` is high.
- R6: Bits 7:4 clear one cycle after a `stop_i` pulse, or after a `start_i` pulse while the bus is busy. A bus is busy after a START and until a STOP. A `start_i` on an idle bus leaves bits 7:4 unchanged.
- R7: When a clearing event and an accepted match occur in the same cycle, the flags take the values of the new match.
- R8: Bits 15:8 equal `pec_i` while `pec_en_i` is high and 0 otherwise, with no register delay. Bits 3:0 always read 0.
- R9: `addr_o` clears one cycle after a `rd_stat2_i` pulse that follows an earlier `rd_stat1_i` pulse. It clears even if a new match set it between the two reads. A `rd_stat2_i` without a preceding `rd_stat1_i` leaves it set.
- R10: While `pe_i` is low, no address is accepted, and `addr_o` and bits 7:4 clear one cycle after `pe_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 7 | Received address |
| addr_valid_i | input | 1 | Address strobe, one cycle |
| start_i | input | 1 | START condition pulse |
| stop_i | input | 1 | STOP condition pulse |
| pe_i | input | 1 | Peripheral enable |
| gc_en_i | input | 1 | General call enable |
| arp_en_i | input | 1 | SMBus address resolution enable |
| host_type_i | input | 1 | SMBus host type select |
| pec_en_i | input | 1 | PEC enable |
| own_addr1_i | input | 7 | Own address 1 |
| own_addr2_i | input | 7 | Own address 2 |
| pec_i | input | 8 | Running PEC value |
| rd_stat1_i | input | 1 | First status word read strobe |
| rd_stat2_i | input | 1 | Second status word read strobe |
| status_o | output | 16 | Status word |
| addr_o | output | 1 | Address matched flag |

## Verification
The hardest cases put two events on the same clock edge or on a tight ordering. One is a STOP landing in the cycle of a fresh match. Another is a new match arriving between the two acknowledge reads. A third is a START on an idle bus, which must be told apart from a repeated START. Directed tasks build each of these by driving the pulses together at one falling edge, or by ordering the START/STOP history before the address so that the internal busy state is known. They then read the flags at the next falling edge.

// File: rtl/i2c_addr_pkg.sv
package i2c_addr_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned PEC_W  = 8;
  localparam int unsigned STAT_W = PEC_W + 8;

  localparam logic [ADDR_W-1:0] GC_ADDR   = 7'h00;
  localparam logic [ADDR_W-1:0] HOST_ADDR = 7'h08;
  localparam logic [ADDR_W-1:0] DFLT_ADDR = 7'h61;

  typedef struct packed {
    logic dual;
    logic host;
    logic dflt;
    logic gc;
  } match_t;
endpackage

// File: rtl/addr_classify.sv
module addr_classify
  import i2c_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic          valid_i,
  input  logic          pe_i,
  input  logic          gc_en_i,
  input  logic          arp_en_i,
  input  logic          host_type_i,
  input  logic [AW-1:0] own1_i,
  input  logic [AW-1:0] own2_i,
  output logic          hit_o,
  output match_t        kind_o
);
  logic own1_hit, own2_hit;

  always_comb begin
    own1_hit    = (addr_i == own1_i);
    own2_hit    = (addr_i == own2_i) && !own1_hit;
    kind_o.dual = own2_hit;
    kind_o.gc   = gc_en_i && (addr_i == AW'(GC_ADDR));
    kind_o.dflt = arp_en_i && (addr_i == AW'(DFLT_ADDR));
    kind_o.host = arp_en_i && host_type_i && (addr_i == AW'(HOST_ADDR));
    hit_o = pe_i && valid_i &&
            (own1_hit || own2_hit || kind_o.gc || kind_o.dflt || kind_o.host);
  end
endmodule

// File: rtl/match_flags.sv
module match_flags
  import i2c_addr_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   pe_i,
  input  logic   start_i,
  input  logic   stop_i,
  input  logic   load_i,
  input  match_t kind_i,
  output match_t flags_o
);
  logic busy_q;
  logic clr;

  // repeated start = start seen while bus already busy
  assign clr = stop_i || (start_i && busy_q) || !pe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           busy_q <= 1'b0;
    else if (!pe_i)        busy_q <= 1'b0;
    else if (stop_i)       busy_q <= 1'b0;
    else if (start_i)      busy_q <= 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flags_o <= '0;
    else if (load_i) flags_o <= kind_i;   // new match wins over clear
    else if (clr)    flags_o <= '0;
  end
endmodule

// File: rtl/addr_ack.sv
module addr_ack (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pe_i,
  input  logic set_i,
  input  logic rd1_i,
  input  logic rd2_i,
  output logic addr_o
);
  logic armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      addr_o  <= 1'b0;
    end else if (!pe_i) begin
      armed_q <= 1'b0;
      addr_o  <= 1'b0;
    end else begin
      if (rd1_i)      armed_q <= 1'b1;
      else if (rd2_i) armed_q <= 1'b0;
      if (set_i)                 addr_o <= 1'b1;
      else if (rd2_i && armed_q) addr_o <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_addr_status.sv
module i2c_addr_status
  import i2c_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PW = PEC_W,
  localparam int unsigned SW = PW + 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] addr_i,
  input  logic          addr_valid_i,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic          pe_i,
  input  logic          gc_en_i,
  input  logic          arp_en_i,
  input  logic          host_type_i,
  input  logic          pec_en_i,
  input  logic [AW-1:0] own_addr1_i,
  input  logic [AW-1:0] own_addr2_i,
  input  logic [PW-1:0] pec_i,
  input  logic          rd_stat1_i,
  input  logic          rd_stat2_i,
  output logic [SW-1:0] status_o,
  output logic          addr_o
);
  logic   hit;
  match_t kind, flags;

  addr_classify #(.AW(AW)) u_cls (
    .addr_i      (addr_i),
    .valid_i     (addr_valid_i),
    .pe_i        (pe_i),
    .gc_en_i     (gc_en_i),
    .arp_en_i    (arp_en_i),
    .host_type_i (host_type_i),
    .own1_i      (own_addr1_i),
    .own2_i      (own_addr2_i),
    .hit_o       (hit),
    .kind_o      (kind)
  );

  match_flags u_flg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .pe_i    (pe_i),
    .start_i (start_i),
    .stop_i  (stop_i),
    .load_i  (hit),
    .kind_i  (kind),
    .flags_o (flags)
  );

  addr_ack u_ack (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pe_i   (pe_i),
    .set_i  (hit),
    .rd1_i  (rd_stat1_i),
    .rd2_i  (rd_stat2_i),
    .addr_o (addr_o)
  );

  assign status_o = {(pec_en_i ? pec_i : {PW{1'b0}}), flags, 4'b0000};
endmodule

// File: rtl/i2c_addr_status_chk.sv
module i2c_addr_status_chk
  import i2c_addr_pkg::*;
#(
  parameter int unsigned AW = ADDR_W,
  parameter int unsigned PW = PEC_W
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          addr_valid_i,
  input logic          stop_i,
  input logic          pe_i,
  input logic          gc_en_i,
  input logic          arp_en_i,
  input logic          host_type_i,
  input logic          pec_en_i,
  input logic          rd_stat2_i,
  input logic [PW+7:0] status_o,
  input logic          addr_o
);
  AST_ADDR_NEEDS_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_o) |-> $past(addr_valid_i && pe_i));                            // R2
  AST_GC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[4]) |-> $past(gc_en_i && addr_valid_i && pe_i));            // R3
  AST_HOST_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[6]) |-> $past(arp_en_i && host_type_i && addr_valid_i));    // R4
  AST_DFLT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(status_o[5]) |-> $past(arp_en_i && addr_valid_i));                   // R5
  AST_STOP_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && !addr_valid_i) |=> (status_o[7:4] == 4'b0));                    // R6
  AST_PEC_HIDDEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pec_en_i |-> (status_o[PW+7:8] == '0));                                   // R8
  AST_ADDR_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_o && !rd_stat2_i && pe_i) |=> addr_o);                               // R9
  AST_PE_OFF_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pe_i |=> (!addr_o && status_o[7:4] == 4'b0));                             // R10
endmodule

bind i2c_addr_status i2c_addr_status_chk #(.AW(AW), .PW(PW)) u_chk (.*);

// File: tb/i2c_addr_status_test.sv
`timescale 1ns/1ps
module i2c_addr_status_test;
  logic       clk_i = 0, rst_ni = 0;
  logic [6:0] addr_i = 0;
  logic       addr_valid_i = 0, start_i = 0, stop_i = 0, pe_i = 0;
  logic       gc_en_i = 0, arp_en_i = 0, host_type_i = 0, pec_en_i = 0;
  logic [6:0] own_addr1_i = 7'h3A, own_addr2_i = 7'h55;
  logic [7:0] pec_i = 0;
  logic       rd_stat1_i = 0, rd_stat2_i = 0;
  logic [15:0] status_o;
  logic        addr_o;
  int vecs = 0, errs = 0;

  always #4 clk_i = ~clk_i;

  i2c_addr_status uut (.*);

  task automatic tick(); @(posedge clk_i); @(negedge clk_i); endtask

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic send(logic [6:0] a);
    addr_i = a; addr_valid_i = 1; tick(); addr_valid_i = 0;
  endtask
  task automatic pulse_stop();  stop_i = 1;  tick(); stop_i = 0;  endtask
  task automatic pulse_start(); start_i = 1; tick(); start_i = 0; endtask
  task automatic ack();
    rd_stat1_i = 1; tick(); rd_stat1_i = 0;
    rd_stat2_i = 1; tick(); rd_stat2_i = 0;
  endtask

  task automatic t_reset();
    chk("R1 status", status_o, 16'h0000);
    chk("R1 addr", {15'b0, addr_o}, 16'h0001 & 16'h0000);
  endtask

  task automatic t_own();
    pulse_start();
    send(7'h3A);
    chk("R2 own1 addr", {15'b0, addr_o}, 16'h1);
    chk("R2 own1 dual", status_o, 16'h0000);
    ack();
    chk("R9 ack clears", {15'b0, addr_o}, 16'h0);
    send(7'h55);
    chk("R2 own2 dual", status_o, 16'h0080);
    chk("R2 own2 addr", {15'b0, addr_o}, 16'h1);
    ack();
    send(7'h11);
    chk("R2 nomatch addr", {15'b0, addr_o}, 16'h0);
    chk("R2 nomatch flags", status_o, 16'h0080);
    pulse_stop();
    chk("R6 stop clears", status_o, 16'h0000);
  endtask

  task automatic t_gc();
    gc_en_i = 0; send(7'h00);
    chk("R3 gc off", {status_o[15:1], addr_o}, 16'h0000);
    gc_en_i = 1; send(7'h00);
    chk("R3 gc on", status_o, 16'h0010);
    chk("R3 gc addr", {15'b0, addr_o}, 16'h1);
    ack(); pulse_stop(); gc_en_i = 0;
  endtask

  task automatic t_host();
    arp_en_i = 1; host_type_i = 0; send(7'h08);
    chk("R4 host no type", {status_o[15:1], addr_o}, 16'h0000);
    arp_en_i = 0; host_type_i = 1; send(7'h08);
    chk("R4 host no arp", {status_o[15:1], addr_o}, 16'h0000);
    arp_en_i = 1; send(7'h08);
    chk("R4 host on", status_o, 16'h0040);
    ack(); pulse_stop(); host_type_i = 0; arp_en_i = 0;
  endtask

  task automatic t_dflt();
    send(7'h61);
    chk("R5 dflt off", {status_o[15:1], addr_o}, 16'h0000);
    arp_en_i = 1; send(7'h61);
    chk("R5 dflt on", status_o, 16'h0020);
    chk("R5 dflt addr", {15'b0, addr_o}, 16'h1);
    ack(); pulse_stop(); arp_en_i = 0;
  endtask

  task automatic t_restart();
    pulse_start(); send(7'h55);
    chk("R6 set before rs", status_o, 16'h0080);
    pulse_start();
    chk("R6 rstart clears", status_o, 16'h0000);
    pulse_stop(); ack();
    send(7'h55);
    pulse_start();
    chk("R6 idle start keeps", status_o, 16'h0080);
    pe_i = 0; tick();
    chk("R10 pe off flags", status_o, 16'h0000);
    chk("R10 pe off addr", {15'b0, addr_o}, 16'h0);
    send(7'h3A);
    chk("R10 no accept", {15'b0, addr_o}, 16'h0);
    pe_i = 1; tick();
  endtask

  task automatic t_collide();
    send(7'h55);
    chk("R7 pre", status_o, 16'h0080);
    gc_en_i = 1; stop_i = 1; send(7'h00); stop_i = 0; gc_en_i = 0;
    chk("R7 match wins", status_o, 16'h0010);
    ack(); pulse_stop();
  endtask

  task automatic t_pec();
    pec_i = 8'hA5; pec_en_i = 0; #1;
    chk("R8 pec hidden", status_o, 16'h0000);
    pec_en_i = 1; #1;
    chk("R8 pec shown", status_o, 16'hA500);
    send(7'h55);
    chk("R8 low nibble", status_o, 16'hA580);
    pec_en_i = 0; ack(); pulse_stop();
  endtask

  task automatic t_ack_seq();
    send(7'h3A);
    rd_stat2_i = 1; tick(); rd_stat2_i = 0;
    chk("R9 rd2 alone", {15'b0, addr_o}, 16'h1);
    rd_stat1_i = 1; tick(); rd_stat1_i = 0;
    send(7'h3A);
    rd_stat2_i = 1; tick(); rd_stat2_i = 0;
    chk("R9 set between reads", {15'b0, addr_o}, 16'h0);
  endtask

  initial begin
    repeat (3) tick();
    rst_ni = 1; tick();
    t_reset();
    pe_i = 1; tick();
    t_own(); t_gc(); t_host(); t_dflt(); t_restart(); t_collide(); t_pec(); t_ack_seq();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog act=hung exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule